// File: doc/BRIEF.md
# Priority Task Dispatcher

This block keeps a small set of compute task queues, each able to hold one pending task, and launches their work into a shader array. A task carries four things: a priority from 0 (background) to 3 (real-time), a resource need per workgroup, a workgroup count and a wavefront-per-workgroup count. The dispatcher starts only the highest-priority waiting task, and only when the free resource pool covers one workgroup of that task. It then sends that task's wavefronts out one per cycle, one workgroup after another. Each workgroup takes its resource share from the pool when its first wavefront leaves.

Completion pulses return resources. Each pulse names the task slot of one finished workgroup, and pulses may arrive in any order. A task is retired, and its tracking slot freed, once all of its issued workgroups have completed. A preempt input ends the running task at the next workgroup boundary. Its workgroups not yet issued are dropped, and the next pick comes from a different queue when another queue holds a task.

Tasks enter on a valid/ready port. The port accepts a task when `in_valid` is high and the queue named by `in_q` is empty, and it holds the offer otherwise. Wavefronts leave on a valid/ready port. A wavefront that is offered but not accepted keeps its fields unchanged until it is taken. The one exception is the first wavefront of a workgroup, which a preempt may withdraw. Completion, preempt, retire and the free count are plain pins.

Top module: `task_dispatcher`

## Requirements
- R1: `in_ready` is high exactly when the queue selected by `in_q` holds no task. A handshake stores the task in that queue, which then turns not ready until the task is started.
- R2: When no task is running, the dispatcher starts the queued task with the highest `in_prio` value (3 highest). Equal priorities go to the lowest queue index. A task starts only if a tracking slot is free and its per-workgroup resource need is at most `res_free`.
- R3: If the best queued task does not fit the free resources, no task starts and no wavefront is issued until it fits. Lower-priority tasks never bypass it.
- R4: `res_free` equals TOTAL_RES after reset. It drops by the running task's need when the first wavefront of each workgroup is accepted, and it never exceeds TOTAL_RES.
- R5: A `cpl_valid` pulse adds the named task's need back to `res_free`. This happens only if `cpl_tid` is a busy slot with more workgroups issued than completed. Any other pulse has no effect.
- R6: A task with workgroup field G and wavefront field V (both encoded as count minus one) issues exactly (G+1)*(V+1) wavefronts, at most one per cycle. They come in order of workgroup index, then wavefront index, each reported on `wave_wg` and `wave_idx`.
- R7: A started task takes the lowest-numbered free tracking slot, and that number is its `wave_tid`.
- R8: When every workgroup of a task has been issued and completed, `ret_valid` pulses for one cycle with `ret_tid`, and the slot becomes free. Tasks may retire in any order.
- R9: While `wave_valid` is high and `wave_ready` low, the wavefront fields hold, unless a preempt withdraws a not-yet-accepted first wavefront.
- R10: A preempt lets the workgroup in progress finish and drops the remaining workgroups. The next start skips the preempted task's queue while another queue holds a task. A preempt with no running task is ignored.
- R11: After reset, no task is queued or running, `wave_valid` and `ret_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Task offer |
| in_ready | output | 1 | Target queue is empty |
| in_q | input | QW | Target queue index |
| in_prio | input | 2 | Priority, 0 background to 3 real-time |
| in_res | input | 5 | Resource need per workgroup |
| in_wgs_m1 | input | 8 | Workgroup count minus one |
| in_waves_m1 | input | 6 | Wavefronts per workgroup minus one |
| wave_valid | output | 1 | Wavefront offered |
| wave_ready | input | 1 | Shader array accepts the wavefront |
| wave_tid | output | TW | Tracking slot of the task |
| wave_wg | output | 8 | Workgroup index within the task |
| wave_idx | output | 6 | Wavefront index within the workgroup |
| cpl_valid | input | 1 | One workgroup completed |
| cpl_tid | input | TW | Slot of the completed workgroup |
| preempt | input | 1 | Stop the running task |
| ret_valid | output | 1 | A task retired this cycle |
| ret_tid | output | TW | Slot of the retired task |
| res_free | output | 5 | Free resource units |

## Verification
A wrong selection shows on the wavefront port within two cycles of the pool freeing up. A task of the wrong priority or queue appears first, and the order of wavefront counts per slot exposes it. A drifting resource count shows at once on `res_free`. It also shows later as a task that never starts or one that starts too early beside a blocked one. A broken completion count shows as a missing, early or repeated `ret_valid` one cycle after the last completion. A preempt fault shows as extra workgroups from the stopped task, or as the same queue being picked again.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int PRIO_W = 2;
  localparam int RES_W  = 5;
  localparam int WG_W   = 8;
  localparam int WV_W   = 6;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [RES_W-1:0]  res;
    logic [WG_W-1:0]   wgs_m1;
    logic [WV_W-1:0]   waves_m1;
  } task_t;
endpackage

// File: rtl/dq_queues.sv
module dq_queues
  import dispatch_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int QW    = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [QW-1:0]    push_q,
  input  task_t            push_task,
  input  logic             pop,
  input  logic             skip_valid,
  input  logic [QW-1:0]    skip_q,
  input  logic [RES_W-1:0] free_res,
  output logic [NUM_Q-1:0] q_valid,
  output logic             sel_valid,
  output logic [QW-1:0]    sel_q,
  output task_t            sel_task
);
  task_t q_task [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    always_ff @(posedge clk) begin
      if (!rst_n)
        q_valid[g] <= 1'b0;
      else if (push && push_q == QW'(g))
        q_valid[g] <= 1'b1;
      else if (pop && sel_q == QW'(g))
        q_valid[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (push && push_q == QW'(g))
        q_task[g] <= push_task;
    end
  end

  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic              others;
  logic              elig;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    sel_q  = '0;
    others = 1'b0;
    elig   = 1'b0;
    for (int i = 0; i < NUM_Q; i++)
      if (q_valid[i] && !(skip_valid && skip_q == QW'(i)))
        others = 1'b1;
    for (int i = 0; i < NUM_Q; i++) begin
      elig = q_valid[i] && !(skip_valid && skip_q == QW'(i) && others);
      if (elig && (!found || q_task[i].prio > best_p)) begin
        found  = 1'b1;
        best_p = q_task[i].prio;
        sel_q  = QW'(i);
      end
    end
    sel_task  = q_task[sel_q];
    sel_valid = found && (sel_task.res <= free_res);
  end
endmodule

// File: rtl/dq_tracker.sv
module dq_tracker
  import dispatch_pkg::*;
#(
  parameter int NUM_SLOT  = 4,
  parameter int TW        = $clog2(NUM_SLOT),
  parameter int TOTAL_RES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [RES_W-1:0] alloc_res,
  input  logic             launch,
  input  logic [TW-1:0]    launch_tid,
  input  logic             finish,
  input  logic [TW-1:0]    finish_tid,
  input  logic             cpl_valid,
  input  logic [TW-1:0]    cpl_tid,
  output logic             slot_avail,
  output logic [TW-1:0]    free_tid,
  output logic [RES_W-1:0] res_free,
  output logic             ret_valid,
  output logic [TW-1:0]    ret_tid
);
  localparam int CW = WG_W + 1;

  logic [NUM_SLOT-1:0] busy;
  logic [NUM_SLOT-1:0] all_out;
  logic [CW-1:0]       n_issued [NUM_SLOT];
  logic [CW-1:0]       n_done   [NUM_SLOT];
  logic [RES_W-1:0]    need     [NUM_SLOT];
  logic                cpl_ok;
  logic [RES_W-1:0]    dec, inc;

  always_comb begin
    slot_avail = 1'b0;
    free_tid   = '0;
    ret_valid  = 1'b0;
    ret_tid    = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        slot_avail = 1'b1;
        free_tid   = TW'(i);
      end
      if (busy[i] && all_out[i] && n_issued[i] == n_done[i]) begin
        ret_valid = 1'b1;
        ret_tid   = TW'(i);
      end
    end
  end

  assign cpl_ok = cpl_valid && busy[cpl_tid] && (n_done[cpl_tid] < n_issued[cpl_tid]);
  assign dec    = launch ? need[launch_tid] : '0;
  assign inc    = cpl_ok ? need[cpl_tid] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      res_free <= RES_W'(TOTAL_RES);
    else
      res_free <= res_free - dec + inc;
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[s]     <= 1'b0;
        all_out[s]  <= 1'b0;
        n_issued[s] <= '0;
        n_done[s]   <= '0;
        need[s]     <= '0;
      end else if (alloc && free_tid == TW'(s)) begin
        busy[s]     <= 1'b1;
        all_out[s]  <= 1'b0;
        n_issued[s] <= '0;
        n_done[s]   <= '0;
        need[s]     <= alloc_res;
      end else begin
        if (ret_valid && ret_tid == TW'(s))
          busy[s] <= 1'b0;
        if (launch && launch_tid == TW'(s))
          n_issued[s] <= n_issued[s] + 1'b1;
        if (finish && finish_tid == TW'(s))
          all_out[s] <= 1'b1;
        if (cpl_ok && cpl_tid == TW'(s))
          n_done[s] <= n_done[s] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dq_issue.sv
module dq_issue
  import dispatch_pkg::*;
#(
  parameter int QW = 2,
  parameter int TW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_valid,
  input  logic [QW-1:0]    sel_q,
  input  task_t            sel_task,
  input  logic             slot_avail,
  input  logic [TW-1:0]    free_tid,
  input  logic [RES_W-1:0] res_free,
  input  logic             wave_ready,
  input  logic             preempt,
  output logic             take,
  output logic [RES_W-1:0] alloc_res,
  output logic             launch,
  output logic             finish,
  output logic [TW-1:0]    act_tid,
  output logic             wave_valid,
  output logic [WG_W-1:0]  wave_wg,
  output logic [WV_W-1:0]  wave_idx,
  output logic             skip_valid,
  output logic [QW-1:0]    skip_q
);
  logic          running, in_wg, pre_flag;
  task_t         act;
  logic [QW-1:0] act_q;
  logic          fits, fire, last_wave, last_wg, stop_pre;

  assign take       = !running && sel_valid && slot_avail;
  assign alloc_res  = sel_task.res;
  assign fits       = res_free >= act.res;
  assign wave_valid = running && (in_wg || (fits && !pre_flag));
  assign fire       = wave_valid && wave_ready;
  assign launch     = fire && !in_wg;
  assign last_wave  = wave_idx == act.waves_m1;
  assign last_wg    = wave_wg == act.wgs_m1;
  assign stop_pre   = running && !in_wg && pre_flag;
  assign finish     = (fire && last_wave && last_wg) || stop_pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      in_wg      <= 1'b0;
      pre_flag   <= 1'b0;
      act        <= '0;
      act_q      <= '0;
      act_tid    <= '0;
      wave_wg    <= '0;
      wave_idx   <= '0;
      skip_valid <= 1'b0;
      skip_q     <= '0;
    end else if (take) begin
      running    <= 1'b1;
      in_wg      <= 1'b0;
      pre_flag   <= 1'b0;
      act        <= sel_task;
      act_q      <= sel_q;
      act_tid    <= free_tid;
      wave_wg    <= '0;
      wave_idx   <= '0;
      skip_valid <= 1'b0;
    end else if (running) begin
      if (preempt)
        pre_flag <= 1'b1;
      if (stop_pre) begin
        running    <= 1'b0;
        pre_flag   <= 1'b0;
        skip_valid <= 1'b1;
        skip_q     <= act_q;
      end else if (fire) begin
        if (last_wave) begin
          in_wg    <= 1'b0;
          wave_idx <= '0;
          wave_wg  <= wave_wg + 1'b1;
          if (last_wg)
            running <= 1'b0;
        end else begin
          in_wg    <= 1'b1;
          wave_idx <= wave_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher
  import dispatch_pkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int NUM_SLOT  = 4,
  parameter int TOTAL_RES = 16,
  parameter int QW        = $clog2(NUM_Q),
  parameter int TW        = $clog2(NUM_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [QW-1:0]     in_q,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic [RES_W-1:0]  in_res,
  input  logic [WG_W-1:0]   in_wgs_m1,
  input  logic [WV_W-1:0]   in_waves_m1,
  output logic              wave_valid,
  input  logic              wave_ready,
  output logic [TW-1:0]     wave_tid,
  output logic [WG_W-1:0]   wave_wg,
  output logic [WV_W-1:0]   wave_idx,
  input  logic              cpl_valid,
  input  logic [TW-1:0]     cpl_tid,
  input  logic              preempt,
  output logic              ret_valid,
  output logic [TW-1:0]     ret_tid,
  output logic [RES_W-1:0]  res_free
);
  logic [NUM_Q-1:0] q_valid;
  logic             sel_valid, take, launch, finish, slot_avail, skip_valid;
  logic [QW-1:0]    sel_q, skip_q;
  task_t            sel_task, push_task;
  logic [TW-1:0]    free_tid, act_tid;
  logic [RES_W-1:0] alloc_res;

  assign in_ready  = !q_valid[in_q];
  assign push_task = '{prio: in_prio, res: in_res, wgs_m1: in_wgs_m1, waves_m1: in_waves_m1};
  assign wave_tid  = act_tid;

  dq_queues #(.NUM_Q(NUM_Q), .QW(QW)) u_q (
    .clk, .rst_n,
    .push(in_valid && in_ready), .push_q(in_q), .push_task,
    .pop(take), .skip_valid, .skip_q, .free_res(res_free),
    .q_valid, .sel_valid, .sel_q, .sel_task
  );

  dq_issue #(.QW(QW), .TW(TW)) u_iss (
    .clk, .rst_n, .sel_valid, .sel_q, .sel_task, .slot_avail, .free_tid,
    .res_free, .wave_ready, .preempt, .take, .alloc_res, .launch, .finish,
    .act_tid, .wave_valid, .wave_wg, .wave_idx, .skip_valid, .skip_q
  );

  dq_tracker #(.NUM_SLOT(NUM_SLOT), .TW(TW), .TOTAL_RES(TOTAL_RES)) u_trk (
    .clk, .rst_n, .alloc(take), .alloc_res,
    .launch, .launch_tid(act_tid), .finish, .finish_tid(act_tid),
    .cpl_valid, .cpl_tid, .slot_avail, .free_tid, .res_free, .ret_valid, .ret_tid
  );
endmodule

// File: rtl/task_dispatcher_chk.sv
module task_dispatcher_chk
  import dispatch_pkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int TOTAL_RES = 16,
  parameter int QW        = 2,
  parameter int TW        = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [QW-1:0]    in_q,
  input logic [NUM_Q-1:0] qv,
  input logic             wave_valid,
  input logic             wave_ready,
  input logic [TW-1:0]    wave_tid,
  input logic [WG_W-1:0]  wave_wg,
  input logic [WV_W-1:0]  wave_idx,
  input logic             cpl_valid,
  input logic             preempt,
  input logic [RES_W-1:0] res_free
);
  a_r1_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> qv[$past(in_q)]);

  a_r4_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    res_free <= RES_W'(TOTAL_RES));

  a_r5_rise_needs_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |=> res_free <= $past(res_free));

  a_r9_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wave_valid && !wave_ready && !preempt |=>
      wave_valid && $stable(wave_tid) && $stable(wave_wg) && $stable(wave_idx));
endmodule

bind task_dispatcher task_dispatcher_chk #(
  .NUM_Q(NUM_Q), .TOTAL_RES(TOTAL_RES), .QW(QW), .TW(TW)
) u_chk (
  .clk, .rst_n, .in_valid, .in_ready, .in_q, .qv(u_q.q_valid),
  .wave_valid, .wave_ready, .wave_tid, .wave_wg, .wave_idx,
  .cpl_valid, .preempt, .res_free
);

// File: tb/sim_task_dispatcher.sv
`timescale 1ns/1ps
module sim_task_dispatcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_q = '0;
  logic [1:0] in_prio = '0;
  logic [4:0] in_res = '0;
  logic [7:0] in_wgs_m1 = '0;
  logic [5:0] in_waves_m1 = '0;
  logic       wave_valid;
  logic       wave_ready = 1'b0;
  logic [1:0] wave_tid;
  logic [7:0] wave_wg;
  logic [5:0] wave_idx;
  logic       cpl_valid = 1'b0;
  logic [1:0] cpl_tid = '0;
  logic       preempt = 1'b0;
  logic       ret_valid;
  logic [1:0] ret_tid;
  logic [4:0] res_free;

  int errs = 0, checks = 0;
  int lg_n = 0, rt_n = 0;
  int lg_tid [64];
  int lg_wg  [64];
  int lg_idx [64];
  int rt_tid [64];
  bit done = 1'b0;

  always #2 clk = ~clk;

  task_dispatcher u0 (.*);

  always @(negedge clk) begin
    if (rst_n && wave_valid && wave_ready && lg_n < 64) begin
      lg_tid[lg_n] = int'(wave_tid);
      lg_wg[lg_n]  = int'(wave_wg);
      lg_idx[lg_n] = int'(wave_idx);
      lg_n++;
    end
    if (rst_n && ret_valid && rt_n < 64) begin
      rt_tid[rt_n] = int'(ret_tid);
      rt_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int q, input int p, input int r, input int g, input int v);
    in_q = 2'(q); in_prio = 2'(p); in_res = 5'(r);
    in_wgs_m1 = 8'(g); in_waves_m1 = 6'(v); in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    step(1);
    in_valid = 1'b0;
  endtask

  task automatic cpl(input int t);
    cpl_tid = 2'(t); cpl_valid = 1'b1;
    step(1);
    cpl_valid = 1'b0;
  endtask

  task automatic clear_logs();
    lg_n = 0; rt_n = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 wave_valid", int'(wave_valid), 0);
    chk("R11 ret_valid", int'(ret_valid), 0);
    chk("R11 in_ready", int'(in_ready), 1);
    chk("R4 reset res_free", int'(res_free), 16);
    step(1);
  endtask

  task automatic t_basic();
    clear_logs();
    preempt = 1'b1; step(1); preempt = 1'b0;
    wave_ready = 1'b1;
    push(0, 1, 4, 1, 2);
    step(14);
    chk("R6 wave count", lg_n, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R6 wg order", lg_wg[i], i / 3);
      chk("R6 idx order", lg_idx[i], i % 3);
      chk("R7 slot zero", lg_tid[i], 0);
    end
    chk("R4 two workgroups taken", int'(res_free), 8);
    cpl(3); step(2);
    chk("R5 idle slot ignored", int'(res_free), 8);
    cpl(0); step(2);
    chk("R5 return", int'(res_free), 12);
    chk("R8 no early retire", rt_n, 0);
    cpl(0); step(2);
    chk("R8 retire count", rt_n, 1);
    chk("R8 retire tid", rt_tid[0], 0);
    cpl(0); step(2);
    chk("R5 retired slot ignored", int'(res_free), 16);
    chk("R10 idle preempt ignored", lg_n, 6);
  endtask

  task automatic t_priority();
    clear_logs();
    push(0, 0, 16, 0, 0);
    step(5);
    chk("R4 pool empty", int'(res_free), 0);
    push(1, 1, 2, 0, 2);
    push(2, 3, 2, 0, 0);
    push(3, 3, 2, 0, 1);
    in_q = 2'd1;
    @(negedge clk);
    chk("R1 full queue not ready", int'(in_ready), 0);
    step(5);
    chk("R2 blocked while pool empty", lg_n, 1);
    cpl(lg_tid[0]);
    step(16);
    chk("R2 wave count", lg_n, 7);
    chk("R2 first is prio3 q2", lg_idx[1], 0);
    chk("R2 next is prio3 q3", lg_idx[3], 1);
    chk("R2 last is prio1", lg_idx[6], 2);
    chk("R2 q3 task one slot", int'(lg_tid[2] == lg_tid[3]), 1);
    chk("R2 q2 and q3 differ", int'(lg_tid[1] != lg_tid[2]), 1);
    chk("R4 three taken", int'(res_free), 10);
    cpl(lg_tid[1]); cpl(lg_tid[2]); cpl(lg_tid[4]);
    step(4);
    chk("R8 all retired", rt_n, 4);
    chk("R5 pool restored", int'(res_free), 16);
  endtask

  task automatic t_nobypass();
    clear_logs();
    push(0, 0, 8, 0, 0);
    step(4);
    push(1, 2, 10, 0, 1);
    push(2, 1, 2, 0, 0);
    step(20);
    chk("R3 no bypass waves", lg_n, 1);
    chk("R3 pool untouched", int'(res_free), 8);
    cpl(lg_tid[0]);
    step(12);
    chk("R3 wave count", lg_n, 4);
    chk("R3 big task first", lg_idx[2], 1);
    chk("R3 small after", int'(lg_tid[3] != lg_tid[1]), 1);
    chk("R4 after both", int'(res_free), 4);
    cpl(lg_tid[1]); cpl(lg_tid[3]);
    step(4);
    chk("R5 pool back", int'(res_free), 16);
  endtask

  task automatic t_preempt();
    clear_logs();
    wave_ready = 1'b0;
    push(2, 1, 1, 7, 1);
    push(0, 0, 1, 0, 0);
    step(3);
    @(negedge clk);
    chk("R9 offered", int'(wave_valid), 1);
    step(2);
    chk("R9 held fields", int'(wave_idx) + int'(wave_wg), 0);
    wave_ready = 1'b1;
    step(3);
    wave_ready = 1'b0;
    preempt = 1'b1; step(1); preempt = 1'b0;
    push(2, 3, 1, 0, 1);
    step(3);
    wave_ready = 1'b1;
    step(16);
    chk("R10 wave count", lg_n, 7);
    chk("R10 wg1 finished", lg_wg[3] * 10 + lg_idx[3], 11);
    chk("R10 other queue next", lg_tid[4], 1);
    chk("R10 other queue one wave", int'(lg_tid[5] != lg_tid[4]), 1);
    chk("R10 same queue last", lg_idx[6], 1);
    chk("R4 after preempt", int'(res_free), 12);
    cpl(1); step(2);
    chk("R8 out of order first", rt_tid[0], 1);
    cpl(0); cpl(0); cpl(lg_tid[5]);
    step(4);
    chk("R8 retire count", rt_n, 3);
    chk("R8 preempted retires", rt_tid[1], 0);
    chk("R5 final pool", int'(res_free), 16);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_priority();
    t_nobypass();
    t_preempt();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule